// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves 64 kb/s channels between serial time-division-multiplexed streams. Each input stream is deserialized into bytes, and every byte lands in a two-frame data memory. For every output slot, a connection memory chooses which input stream and channel to send. It can instead send a fixed byte held in the connection word, or leave the slot undriven. Host logic fills the connection memory through a plain write/read register port.

The default configuration has four input and four output streams of 32 channels each, which is a 2.048 Mb/s stream. A single active-low frame pulse aligns both directions. Each bit lasts two clock cycles and is sent most significant bit first. Each output slot can choose a short variable delay or a fixed one-frame delay, so the bytes of a multi-slot wideband channel stay in one frame. Each output slot can also switch a half-channel (nibble) instead of a full byte. The output pins are driven by an external pad cell that follows the per-stream drive signal.

Top module: `tsi_switch`

## Requirements
- R1: After reset, every connection word reads back as zero and every output stream is undriven in every slot until the host writes a connection.
- R2: When fp_n is sampled low at a clock edge, the next cycle is the first clock of channel 0, bit 0. Each bit lasts 2 clocks, most significant bit first, and input bits are sampled at the end of the second clock. Output bit b of slot c appears on sto during frame cycles c*16+2b+1 and c*16+2b+2, one clock after the matching input timing.
- R3: A host write stores word host_wdata at address {stream, channel}, which is bits [6:5] and [4:0] by default. host_rdata returns the word at host_addr one clock later. Bits 15:12 are ignored on write and read back as zero.
- R4: Connection word fields: bits [4:0] hold the source channel, bits [6:5] the source stream, bit 7 the nibble select, bit 8 the output enable, bit 9 message mode, bit 10 constant delay and bit 11 nibble mode.
- R5: Any input channel can feed any output slot, and one input channel can feed many output slots in the same frame.
- R6: With variable delay, an output slot c fed by source channel s carries the byte received in the same frame when s < c, and the byte from the previous frame when s >= c.
- R7: With constant delay, an output slot always carries the source byte received in the previous frame, whatever the channel order.
- R8: When the output-enable bit is clear, sto_drv stays low for the whole slot.
- R9: In message mode, the slot carries bits [7:0] of the connection word instead of switched data.
- R10: In nibble mode, only bits 0 to 3 of the slot are driven and bits 4 to 7 are undriven. For switched data, those four bits carry the source's upper nibble when bit 7 is 0 and its lower nibble when bit 7 is 1. In message mode they carry the message's upper nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, two cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_n | input | 1 | Active-low frame pulse, one clock before channel 0 bit 0 |
| sti | input | NS | Serial input streams |
| host_wr | input | 1 | Connection memory write strobe |
| host_addr | input | log2(NS)+log2(NCH) | Connection address {stream, channel} |
| host_wdata | input | 16 | Connection word to write |
| host_rdata | output | 16 | Connection word read back, one clock latency |
| sto | output | NS | Serial output data |
| sto_drv | output | NS | Per-stream pad drive enable; low means high-impedance |

## Verification
The hardest cases to reach are the edges of the variable-delay rule. A source channel equal to the output slot, or one channel below it, must land in different frames. The first slot of a frame has no earlier channel at all. The stimulus gives every stream a fixed channel offset (0, -1, +1 and a scattered one), so each frame covers these edges on every slot. The input bytes are a known function of frame, stream and channel, so the frame a byte came from can be read off its value. A later phase mixes all modes across neighbouring slots. This shows that the drive enable and the nibble cut-off never leak from one slot into the next.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
   localparam int WORD_W = 16;
   localparam int CFG_W  = 12;
   localparam int BYTE_W = 8;

   // connection word, bit 11 down to bit 0
   typedef struct packed {
      logic       nib;    // [11] half-channel switching
      logic       cdly;   // [10] constant one-frame delay
      logic       msg;    // [9]  send low byte as message
      logic       oe;     // [8]  drive the slot
      logic [7:0] low;    // [7] nibble select, [6:5] stream, [4:0] channel / message byte
   } cfg_t;

   localparam int ST_LSB   = 5;
   localparam int NSEL_BIT = 7;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
   parameter int NCH  = 32,
   localparam int CH_W = $clog2(NCH),
   localparam int POS_W = CH_W + 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            fp_n,
   output logic [CH_W-1:0] ch_idx,
   output logic [2:0]      bit_idx,
   output logic            ph,
   output logic            cur
);
   localparam logic [POS_W-1:0] LAST = POS_W'(NCH * 16 - 1);

   logic [POS_W-1:0] pos;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos <= '0;
         cur <= 1'b0;
      end else begin
         if (!fp_n || pos == LAST) cur <= ~cur;
         if (!fp_n || pos == LAST) pos <= '0;
         else                      pos <= pos + 1'b1;
      end
   end

   assign ch_idx  = pos[POS_W-1:4];
   assign bit_idx = pos[3:1];
   assign ph      = pos[0];

   assert_fp_align_R2: assert property (@(posedge clk) disable iff (rst)
      !fp_n |=> (pos == '0));

   assert_buf_swap_R7: assert property (@(posedge clk) disable iff (rst)
      (pos != '0) |-> $stable(cur));
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
   parameter int NS = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NS-1:0]       sti,
   input  logic [2:0]          bit_idx,
   input  logic                ph,
   output logic                wr,
   output logic [NS-1:0][7:0]  wr_bytes
);
   assign wr = ph && (bit_idx == 3'd7);

   for (genvar s = 0; s < NS; s++) begin : g_lane
      logic [6:0] acc;
      always_ff @(posedge clk) begin
         if (rst)     acc <= '0;
         else if (ph) acc <= {acc[5:0], sti[s]};
      end
      assign wr_bytes[s] = {acc, sti[s]};
   end
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
   parameter int NS  = 4,
   parameter int NCH = 32,
   localparam int CH_W = $clog2(NCH),
   localparam int ST_W = $clog2(NS)
) (
   input  logic                       clk,
   input  logic                       wr,
   input  logic                       wr_buf,
   input  logic [CH_W-1:0]            wr_ch,
   input  logic [NS-1:0][7:0]         wr_bytes,
   input  logic [NS-1:0]              rd_buf,
   input  logic [NS-1:0][ST_W-1:0]    rd_st,
   input  logic [NS-1:0][CH_W-1:0]    rd_ch,
   output logic [NS-1:0][7:0]         rd_data
);
   logic [7:0] mem [2][NS][NCH];

   always_ff @(posedge clk) begin
      if (wr) begin
         for (int s = 0; s < NS; s++) mem[wr_buf][s][wr_ch] <= wr_bytes[s];
      end
   end

   for (genvar p = 0; p < NS; p++) begin : g_rd
      assign rd_data[p] = mem[rd_buf[p]][rd_st[p]][rd_ch[p]];
   end
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
   import tsi_pkg::*;
#(
   parameter int NS  = 4,
   parameter int NCH = 32,
   localparam int CH_W = $clog2(NCH),
   localparam int ST_W = $clog2(NS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   host_wr,
   input  logic [ST_W+CH_W-1:0]   host_addr,
   input  logic [CFG_W-1:0]       host_wdata,
   output logic [WORD_W-1:0]      host_rdata,
   input  logic [CH_W-1:0]        lk_ch,
   output cfg_t [NS-1:0]          lk_cfg
);
   cfg_t cm [NS][NCH];

   logic [ST_W-1:0] a_st;
   logic [CH_W-1:0] a_ch;
   assign a_st = host_addr[ST_W+CH_W-1:CH_W];
   assign a_ch = host_addr[CH_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NS; s++)
            for (int c = 0; c < NCH; c++) cm[s][c] <= '0;
         host_rdata <= '0;
      end else begin
         if (host_wr) cm[a_st][a_ch] <= cfg_t'(host_wdata);
         host_rdata <= {{(WORD_W-CFG_W){1'b0}}, cm[a_st][a_ch]};
      end
   end

   for (genvar o = 0; o < NS; o++) begin : g_lk
      assign lk_cfg[o] = cm[o][lk_ch];
   end

   assert_host_store_R3: assert property (@(posedge clk) disable iff (rst)
      host_wr |=> (cm[$past(a_st)][$past(a_ch)] == $past(host_wdata)));
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
   import tsi_pkg::*;
#(
   parameter int NS  = 4,
   parameter int NCH = 32,
   localparam int CH_W = $clog2(NCH),
   localparam int ST_W = $clog2(NS)
) (
   input  logic             clk,
   input  logic             rst,
   input  cfg_t             cfg,
   input  logic [CH_W-1:0]  ch_idx,
   input  logic [2:0]       bit_idx,
   input  logic             ph,
   input  logic             cur,
   output logic             rd_buf,
   output logic [ST_W-1:0]  rd_st,
   output logic [CH_W-1:0]  rd_ch,
   input  logic [7:0]       rd_data,
   output logic             sto,
   output logic             drv
);
   logic       arrived, load, cut;
   logic [7:0] nib_byte, slot_byte, sh;
   logic       nib_q;

   assign rd_ch   = cfg.low[CH_W-1:0];
   assign rd_st   = cfg.low[ST_LSB +: ST_W];
   assign arrived = rd_ch < ch_idx;
   assign rd_buf  = (cfg.cdly || !arrived) ? ~cur : cur;

   assign nib_byte  = {cfg.low[NSEL_BIT] ? rd_data[3:0] : rd_data[7:4], 4'h0};
   assign slot_byte = cfg.msg ? cfg.low : (cfg.nib ? nib_byte : rd_data);

   assign load = !ph && (bit_idx == 3'd0);
   assign cut  = !ph && (bit_idx == 3'd4);

   always_ff @(posedge clk) begin
      if (rst) begin
         sh    <= '0;
         drv   <= 1'b0;
         nib_q <= 1'b0;
      end else if (load) begin
         sh    <= slot_byte;
         drv   <= cfg.oe;
         nib_q <= cfg.nib;
      end else if (!ph) begin
         sh <= {sh[6:0], 1'b0};
         if (cut && nib_q) drv <= 1'b0;
      end
   end

   assign sto = sh[7];

   assert_drv_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!load && !cut) |=> $stable(drv));

   assert_nib_cut_R10: assert property (@(posedge clk) disable iff (rst)
      (cut && nib_q) |=> !drv);

   assert_msg_byte_R9: assert property (@(posedge clk) disable iff (rst)
      (load && cfg.msg) |=> (sh == $past(cfg.low)));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
   import tsi_pkg::*;
#(
   parameter int NS  = 4,
   parameter int NCH = 32
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             fp_n,
   input  logic [NS-1:0]                    sti,
   input  logic                             host_wr,
   input  logic [$clog2(NS)+$clog2(NCH)-1:0] host_addr,
   input  logic [15:0]                      host_wdata,
   output logic [15:0]                      host_rdata,
   output logic [NS-1:0]                    sto,
   output logic [NS-1:0]                    sto_drv
);
   localparam int CH_W = $clog2(NCH);
   localparam int ST_W = $clog2(NS);

   if (NS != 2 && NS != 4) begin : g_bad_ns
      $error("tsi_switch: NS must be 2 or 4");
   end
   if (NCH < 2 || NCH > 32 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("tsi_switch: NCH must be a power of two from 2 to 32");
   end

   logic [CH_W-1:0]         ch_idx;
   logic [2:0]              bit_idx;
   logic                    ph, cur, wr;
   logic [NS-1:0][7:0]      wr_bytes, rd_data;
   logic [NS-1:0]           rd_buf;
   logic [NS-1:0][ST_W-1:0] rd_st;
   logic [NS-1:0][CH_W-1:0] rd_ch;
   cfg_t [NS-1:0]           lk_cfg;
   logic                    unused_hi;

   assign unused_hi = ^host_wdata[15:CFG_W];

   tsi_timing #(.NCH(NCH)) u_tim (
      .clk(clk), .rst(rst), .fp_n(fp_n),
      .ch_idx(ch_idx), .bit_idx(bit_idx), .ph(ph), .cur(cur));

   tsi_rx #(.NS(NS)) u_rx (
      .clk(clk), .rst(rst), .sti(sti), .bit_idx(bit_idx), .ph(ph),
      .wr(wr), .wr_bytes(wr_bytes));

   tsi_dmem #(.NS(NS), .NCH(NCH)) u_dm (
      .clk(clk), .wr(wr), .wr_buf(cur), .wr_ch(ch_idx), .wr_bytes(wr_bytes),
      .rd_buf(rd_buf), .rd_st(rd_st), .rd_ch(rd_ch), .rd_data(rd_data));

   tsi_cmem #(.NS(NS), .NCH(NCH)) u_cm (
      .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata[CFG_W-1:0]), .host_rdata(host_rdata),
      .lk_ch(ch_idx), .lk_cfg(lk_cfg));

   for (genvar o = 0; o < NS; o++) begin : g_out
      tsi_tx #(.NS(NS), .NCH(NCH)) u_tx (
         .clk(clk), .rst(rst), .cfg(lk_cfg[o]), .ch_idx(ch_idx),
         .bit_idx(bit_idx), .ph(ph), .cur(cur),
         .rd_buf(rd_buf[o]), .rd_st(rd_st[o]), .rd_ch(rd_ch[o]),
         .rd_data(rd_data[o]), .sto(sto[o]), .drv(sto_drv[o]));
   end
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
   localparam int NS  = 4;
   localparam int NCH = 32;
   localparam int FR  = NCH * 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fp_n = 1'b1;
   logic [NS-1:0] sti = '0;
   logic        host_wr = 1'b0;
   logic [6:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic [NS-1:0] sto, sto_drv;

   always #5 clk = ~clk;

   tsi_switch #(.NS(NS), .NCH(NCH)) u0 (
      .clk(clk), .rst(rst), .fp_n(fp_n), .sti(sti),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .sto(sto), .sto_drv(sto_drv));

   int n_cmp = 0, n_bad = 0;
   int g = -2;
   bit run = 0, chk_en = 0, done = 0;
   string chk_tag = "";
   logic [15:0] shadow [NS][NCH];

   function automatic logic [7:0] pat(int f, int s, int c);
      return 8'(f * 37 + s * 71 + c * 5 + 3);
   endfunction

   function automatic logic [15:0] cfgword(int phz, int o, int c);
      int k, sc, s, m;
      logic [15:0] w;
      w = '0;
      if (phz == 1 || phz == 2) begin
         k  = (o == 0) ? 0 : (o == 1) ? 31 : (o == 2) ? 1 : (c * 7) % 32;
         sc = (c + k) % 32;
         s  = (o + 1 + c) % 4;
         w  = 16'h0100 | 16'(sc) | 16'(s << 5) | ((phz == 2) ? 16'h0400 : 16'h0);
      end else if (phz == 3) begin
         m = (o * 5 + c) % 5;
         case (m)
            0: w = 16'hA100 | 16'((c * 3 + o) % 32) | 16'(o << 5);
            1: w = 16'h5500 | 16'((c * 3 + o) % 32) | 16'(o << 5);
            2: w = 16'h0300 | 16'(8'(c * 9 + o * 50 + 1));
            3: w = 16'h0600 | 16'(8'(c * 13 + 7));
            default: w = 16'h0900 | 16'(31 - c) | 16'((3 - o) << 5)
                         | 16'((c & 1) << 7) | 16'(((c >> 1) & 1) << 10);
         endcase
      end else if (phz == 4) begin
         w = 16'h0100 | 16'd16 | 16'(3 << 5);
      end
      return w;
   endfunction

   // frame driver and output checker, both on the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (run) begin
            g = g + 1;
            if (g < 0) begin
               fp_n = 1'b0;
            end else begin
               int p, f, c, b;
               p = g % FR; f = g / FR; c = p / 16; b = (p % 16) / 2;
               if (chk_en && (p % 2 == 1)) begin
                  for (int o = 0; o < NS; o++) begin
                     logic [15:0] w;
                     logic [7:0] src, byt;
                     logic edrv, ebit;
                     int frm;
                     string tag;
                     w = shadow[o][c];
                     edrv = w[8] && !(w[11] && b >= 4);
                     frm = (w[10] || !(int'(w[4:0]) < c)) ? f - 1 : f;
                     src = pat(frm, int'(w[6:5]), int'(w[4:0]));
                     byt = w[9] ? w[7:0] :
                           (w[11] ? {w[7] ? src[3:0] : src[7:4], 4'h0} : src);
                     ebit = byt[7 - b];
                     if (chk_tag != "")          tag = chk_tag;
                     else if (!w[8])             tag = "R8";
                     else if (w[11])             tag = "R10";
                     else if (w[9])              tag = "R9";
                     else if (w[10])             tag = "R7";
                     else                        tag = "R6";
                     n_cmp++;
                     if (sto_drv[o] !== edrv || (edrv && sto[o] !== ebit)) begin
                        n_bad++;
                        $display("FAIL %s (R2,R4) out=%0d slot=%0d bit=%0d frame=%0d actual drv=%b d=%b expected drv=%b d=%b",
                                 tag, o, c, b, f, sto_drv[o], sto[o], edrv, ebit);
                     end
                  end
               end
               fp_n = (p == FR - 1) ? 1'b0 : 1'b1;
               for (int s = 0; s < NS; s++) begin
                  logic [7:0] v;
                  v = pat(f, s, c);
                  sti[s] = v[7 - b];
               end
            end
         end
      end
   end

   task automatic host_write(int o, int c, logic [15:0] w);
      @(negedge clk);
      host_wr = 1'b1; host_addr = {2'(o), 5'(c)}; host_wdata = w;
   endtask

   task automatic program_phase(int phz);
      for (int o = 0; o < NS; o++)
         for (int c = 0; c < NCH; c++) begin
            logic [15:0] w;
            w = cfgword(phz, o, c);
            host_write(o, c, w);
            shadow[o][c] = w & 16'h0FFF;
         end
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic run_check(string tag);
      int k;
      @(posedge clk);
      k = g / FR + 1;
      while (g < k * FR) @(posedge clk);
      chk_tag = tag; chk_en = 1;
      while (g < (k + 2) * FR) @(posedge clk);
      chk_en = 0;
   endtask

   task automatic readback(int o, int c, string tag);
      @(negedge clk);
      host_addr = {2'(o), 5'(c)};
      @(negedge clk);
      n_cmp++;
      if (host_rdata !== shadow[o][c]) begin
         n_bad++;
         $display("FAIL %s readback out=%0d ch=%0d actual=%h expected=%h",
                  tag, o, c, host_rdata, shadow[o][c]);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (R2) actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int o = 0; o < NS; o++)
         for (int c = 0; c < NCH; c++) shadow[o][c] = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: connection memory cleared by reset
      readback(0, 0, "R1"); readback(1, 17, "R1"); readback(3, 31, "R1"); readback(2, 5, "R1");
      @(posedge clk); run = 1;
      // R1: no slot driven before any connection is written
      run_check("R1");
      // R6: variable delay around s == c, s == c-1, s == c+1 and slot 0
      program_phase(1); run_check("");
      // R7: constant delay with the same sources
      program_phase(2); run_check("");
      // R8 R9 R10 mixed per slot, upper word bits set to exercise R3
      program_phase(3); run_check("");
      for (int o = 0; o < NS; o++)
         for (int c = 0; c < NCH; c++) readback(o, c, "R3");
      // R5: one source feeds every output slot
      program_phase(4); run_check("R5");
      done = 1;
      summary();
      $finish;
   end
endmodule